// File: doc/BRIEF.md
# Critical-Word-First Cache Line Fill

This controller refills one cache line after a miss. A miss request gives a line address and the offset of the word the processor is waiting for. The controller sends one burst request to a word-per-beat memory port and places each returning word in a line buffer. On the beat that carries the wanted word it answers the processor straight away. The remaining beats keep filling the buffer while the processor runs on.

A per-request order select chooses between two burst orders. In wrapped order the burst begins at the wanted word and wraps around the end of the line. In linear order the burst begins at word 0, and the answer goes out when the wanted word's beat arrives. A side port lets the processor read any word of the current line that is already in the buffer. A one-cycle completion strobe, together with the whole line, tells an outer cache that it may mark the line valid.

Top module: `cwf_line_fill`

## Requirements
- R1: `miss_ready` is high only while idle. When `miss_valid` and `miss_ready` are both high at a clock edge, `mem_req_valid` is high for exactly the following cycle. In that cycle `mem_req_line` equals the accepted line, and `mem_req_first` equals the accepted offset when `miss_wrap`=1, or 0 when `miss_wrap`=0.
- R2: With `miss_wrap`=1, beat i of the burst (i = 0..7) is stored as word (offset + i) mod 8 of the line.
- R3: With `miss_wrap`=0, beat i of the burst is stored as word i of the line.
- R4: `cpu_rsp_valid` rises combinationally in the same cycle as the beat (`mem_rvalid`=1) that carries the requested word, and `cpu_rsp_data` equals `mem_rdata` in that cycle.
- R5: Each accepted miss produces exactly one `cpu_rsp_valid` cycle. No response is produced while idle.
- R6: `fill_done` is high for exactly one cycle: the cycle after the eighth valid beat. During that cycle, word k of the line sits in `fill_line[k*32 +: 32]`.
- R7: From acceptance through the `fill_done` cycle, `miss_ready` stays low and `miss_valid` has no effect. `miss_ready` returns high in the cycle after `fill_done`.
- R8: `hit_rsp_valid` is high exactly when `hit_req` is high, `hit_line` equals the line being filled or last filled, and word `hit_offset` has already been written in an earlier cycle. `hit_rsp_data` then holds that word.
- R9: `mem_rvalid` beats are ignored outside the fill phase. They change neither the buffer nor any response.
- R10: After reset, `miss_ready`=1 and `mem_req_valid`, `cpu_rsp_valid`, `hit_rsp_valid`, `fill_done` are 0, and `fill_line` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_offset | input | OFFS_W | Word wanted by the processor |
| miss_wrap | input | 1 | 1: wrapped order, 0: linear order |
| miss_ready | output | 1 | Controller idle, can take a miss |
| mem_req_valid | output | 1 | One-cycle burst request |
| mem_req_line | output | LINE_W | Line address of the burst |
| mem_req_first | output | OFFS_W | Word index of the first beat |
| mem_rvalid | input | 1 | Memory beat strobe |
| mem_rdata | input | DATA_W | Memory beat data |
| cpu_rsp_valid | output | 1 | Requested word returned this cycle |
| cpu_rsp_data | output | DATA_W | Requested word |
| hit_req | input | 1 | Processor read of a buffered word |
| hit_line | input | LINE_W | Line address of that read |
| hit_offset | input | OFFS_W | Word index of that read |
| hit_rsp_valid | output | 1 | Word is present in the buffer |
| hit_rsp_data | output | DATA_W | Buffered word |
| fill_done | output | 1 | Line complete, one-cycle strobe |
| fill_line | output | DATA_W*WORDS | Whole line buffer, word k at bits k*DATA_W |

## Verification
The bench drives misses in both orders, with offsets at 0, at 7 and in the middle, and with idle gaps between beats. A design that counted idle cycles as beats, or that added the start offset in linear order, would place words in the wrong slots of `fill_line` or answer on the wrong beat. The bench also checks that there is only one answer per miss, that a second miss offered mid-fill never starts a burst, and that stray beats while idle are dropped. On the side port it asks for the word written one beat earlier, which must hit, and for the word about to arrive, which must not. A design that forwarded the live beat or cleared presence late would fail that probe.

// File: rtl/cwf_pkg.sv
`timescale 1ns/1ps
package cwf_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int WORDS_DEF  = 8;
    localparam int LINE_W_DEF = 27;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2,
        ST_DONE = 2'd3
    } fill_state_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_WRAP   = 1'b1
    } fill_order_e;

    function automatic fill_order_e order_of(input logic wrap);
        return wrap ? ORD_WRAP : ORD_LINEAR;
    endfunction

    function automatic fill_state_e next_state(
        input fill_state_e cur,
        input logic        accept,
        input logic        beat_fire,
        input logic        last_beat
    );
        fill_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE: if (accept) nxt = ST_REQ;
            ST_REQ:  nxt = ST_FILL;
            ST_FILL: if (beat_fire && last_beat) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cwf_beat_seq.sv
`timescale 1ns/1ps
module cwf_beat_seq
    import cwf_pkg::*;
#(
    parameter int WORDS  = WORDS_DEF,
    parameter int OFFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OFFS_W-1:0] load_word,
    input  fill_order_e       load_order,
    input  logic              beat_fire,
    output logic [OFFS_W-1:0] cur_word,
    output logic              last_beat
);
    localparam logic [OFFS_W-1:0] LAST_CNT = OFFS_W'(WORDS - 1);

    logic [OFFS_W-1:0] base_q;
    logic [OFFS_W-1:0] cnt_q;
    fill_order_e       order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            cnt_q   <= '0;
            order_q <= ORD_LINEAR;
        end else if (load) begin
            base_q  <= load_word;
            cnt_q   <= '0;
            order_q <= load_order;
        end else if (beat_fire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        if (order_q == ORD_WRAP) cur_word = base_q + cnt_q;
        else                     cur_word = cnt_q;
    end

    assign last_beat = (cnt_q == LAST_CNT);

endmodule

// File: rtl/cwf_line_buf.sv
`timescale 1ns/1ps
module cwf_line_buf
    import cwf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int WORDS  = WORDS_DEF,
    parameter int OFFS_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [OFFS_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [OFFS_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_present,
    output logic [DATA_W*WORDS-1:0] line_flat
);
    logic [DATA_W-1:0] word_q [WORDS];
    logic [WORDS-1:0]  present_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [OFFS_W-1:0] IDX = OFFS_W'(w);
        logic hit_w;
        assign hit_w = wr_en && (wr_idx == IDX);

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[w]    <= '0;
                present_q[w] <= 1'b0;
            end else if (clear) begin
                present_q[w] <= 1'b0;
            end else if (hit_w) begin
                word_q[w]    <= wr_data;
                present_q[w] <= 1'b1;
            end
        end

        assign line_flat[w*DATA_W +: DATA_W] = word_q[w];
    end

    assign rd_data    = word_q[rd_idx];
    assign rd_present = present_q[rd_idx];

endmodule

// File: rtl/cwf_rsp_fwd.sv
`timescale 1ns/1ps
module cwf_rsp_fwd
    import cwf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int WORDS  = WORDS_DEF,
    parameter int OFFS_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [OFFS_W-1:0] arm_word,
    input  logic              beat_fire,
    input  logic [OFFS_W-1:0] beat_word,
    input  logic [DATA_W-1:0] beat_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic              armed_q;
    logic [OFFS_W-1:0] target_q;

    assign rsp_valid = armed_q && beat_fire && (beat_word == target_q);
    assign rsp_data  = rsp_valid ? beat_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            target_q <= '0;
        end else if (arm) begin
            armed_q  <= 1'b1;
            target_q <= arm_word;
        end else if (rsp_valid) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cwf_line_fill.sv
`timescale 1ns/1ps
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int WORDS  = WORDS_DEF,
    parameter int LINE_W = LINE_W_DEF,
    localparam int OFFS_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    input  logic [LINE_W-1:0]       miss_line,
    input  logic [OFFS_W-1:0]       miss_offset,
    input  logic                    miss_wrap,
    output logic                    miss_ready,
    output logic                    mem_req_valid,
    output logic [LINE_W-1:0]       mem_req_line,
    output logic [OFFS_W-1:0]       mem_req_first,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    cpu_rsp_valid,
    output logic [DATA_W-1:0]       cpu_rsp_data,
    input  logic                    hit_req,
    input  logic [LINE_W-1:0]       hit_line,
    input  logic [OFFS_W-1:0]       hit_offset,
    output logic                    hit_rsp_valid,
    output logic [DATA_W-1:0]       hit_rsp_data,
    output logic                    fill_done,
    output logic [DATA_W*WORDS-1:0] fill_line
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [OFFS_W-1:0] offset;
        fill_order_e       order;
    } miss_ctx_t;

    fill_state_e       state_q;
    miss_ctx_t         ctx_q;
    logic              accept;
    logic              beat_fire;
    logic              last_beat;
    logic [OFFS_W-1:0] beat_word;
    logic [OFFS_W-1:0] first_word;
    logic              buf_present;
    logic [DATA_W-1:0] buf_data;

    assign accept     = miss_valid && (state_q == ST_IDLE);
    assign beat_fire  = mem_rvalid && (state_q == ST_FILL);
    assign first_word = (order_of(miss_wrap) == ORD_WRAP) ? miss_offset : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '{line: '0, offset: '0, order: ORD_LINEAR};
        end else begin
            state_q <= next_state(state_q, accept, beat_fire, last_beat);
            if (accept) begin
                ctx_q <= '{line: miss_line, offset: miss_offset,
                           order: order_of(miss_wrap)};
            end
        end
    end

    cwf_beat_seq #(.WORDS(WORDS), .OFFS_W(OFFS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_word (first_word),
        .load_order(order_of(miss_wrap)),
        .beat_fire (beat_fire),
        .cur_word  (beat_word),
        .last_beat (last_beat)
    );

    cwf_line_buf #(.DATA_W(DATA_W), .WORDS(WORDS), .OFFS_W(OFFS_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .wr_en     (beat_fire),
        .wr_idx    (beat_word),
        .wr_data   (mem_rdata),
        .rd_idx    (hit_offset),
        .rd_data   (buf_data),
        .rd_present(buf_present),
        .line_flat (fill_line)
    );

    cwf_rsp_fwd #(.DATA_W(DATA_W), .WORDS(WORDS), .OFFS_W(OFFS_W)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .arm      (accept),
        .arm_word (miss_offset),
        .beat_fire(beat_fire),
        .beat_word(beat_word),
        .beat_data(mem_rdata),
        .rsp_valid(cpu_rsp_valid),
        .rsp_data (cpu_rsp_data)
    );

    assign miss_ready    = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_line  = ctx_q.line;
    assign mem_req_first = (ctx_q.order == ORD_WRAP) ? ctx_q.offset : '0;
    assign fill_done     = (state_q == ST_DONE);

    assign hit_rsp_valid = hit_req && (hit_line == ctx_q.line) && buf_present;
    assign hit_rsp_data  = hit_rsp_valid ? buf_data : '0;

endmodule

// File: rtl/cwf_line_fill_chk.sv
`timescale 1ns/1ps
module cwf_line_fill_chk #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    parameter int LINE_W = 27,
    localparam int OFFS_W = $clog2(WORDS),
    localparam int CNT_W  = $clog2(WORDS) + 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    miss_valid,
    input logic [LINE_W-1:0]       miss_line,
    input logic [OFFS_W-1:0]       miss_offset,
    input logic                    miss_wrap,
    input logic                    miss_ready,
    input logic                    mem_req_valid,
    input logic [LINE_W-1:0]       mem_req_line,
    input logic [OFFS_W-1:0]       mem_req_first,
    input logic                    mem_rvalid,
    input logic [DATA_W-1:0]       mem_rdata,
    input logic                    cpu_rsp_valid,
    input logic [DATA_W-1:0]       cpu_rsp_data,
    input logic                    hit_req,
    input logic [LINE_W-1:0]       hit_line,
    input logic [OFFS_W-1:0]       hit_offset,
    input logic                    hit_rsp_valid,
    input logic [DATA_W-1:0]       hit_rsp_data,
    input logic                    fill_done,
    input logic [DATA_W*WORDS-1:0] fill_line
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);

    logic [1:0]       rsp_cnt;
    logic [CNT_W-1:0] beat_cnt;
    logic             filling;

    assign filling = !miss_ready && !mem_req_valid && !fill_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_cnt  <= '0;
            beat_cnt <= '0;
        end else if (miss_valid && miss_ready) begin
            rsp_cnt  <= '0;
            beat_cnt <= '0;
        end else begin
            if (cpu_rsp_valid && rsp_cnt != 2'd3) rsp_cnt <= rsp_cnt + 2'd1;
            if (filling && mem_rvalid) beat_cnt <= beat_cnt + 1'b1;
        end
    end

    AST_REQ_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> (mem_req_valid && !miss_ready)); // R1
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid); // R1
    AST_RSP_ON_BEAT: assert property (@(posedge clk) disable iff (rst)
        cpu_rsp_valid |-> (mem_rvalid && cpu_rsp_data == mem_rdata)); // R4
    AST_ONE_RSP: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (rsp_cnt == 2'd1)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> (!fill_done && miss_ready)); // R6
    AST_DONE_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
        fill_done |-> (beat_cnt == FULL)); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!miss_ready && !fill_done) |=> !miss_ready); // R7
    AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        hit_rsp_valid |-> (hit_req && hit_line == mem_req_line)); // R8
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        miss_ready |-> !cpu_rsp_valid); // R9

endmodule

bind cwf_line_fill cwf_line_fill_chk #(
    .DATA_W(DATA_W), .WORDS(WORDS), .LINE_W(LINE_W)
) u_chk (.*);

// File: tb/tb_cwf_line_fill.sv
`timescale 1ns/1ps
module tb_cwf_line_fill;

    localparam int DATA_W = 32;
    localparam int WORDS  = 8;
    localparam int LINE_W = 27;
    localparam int NVEC   = 6;

    typedef struct packed {
        logic        wrap;
        logic [15:0] line;
        logic [2:0]  off;
        logic [7:0]  gaps;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        vec_t'({1'b1, 16'h0123, 3'd5, 8'b0000_0000}),
        vec_t'({1'b1, 16'h0456, 3'd0, 8'b0010_0100}),
        vec_t'({1'b1, 16'h0789, 3'd7, 8'b1000_0010}),
        vec_t'({1'b0, 16'h0ABC, 3'd5, 8'b0000_0000}),
        vec_t'({1'b0, 16'h0DEF, 3'd0, 8'b0101_0000}),
        vec_t'({1'b0, 16'h0F00, 3'd7, 8'b0000_0110})
    };

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    miss_valid;
    logic [LINE_W-1:0]       miss_line;
    logic [2:0]              miss_offset;
    logic                    miss_wrap;
    logic                    miss_ready;
    logic                    mem_req_valid;
    logic [LINE_W-1:0]       mem_req_line;
    logic [2:0]              mem_req_first;
    logic                    mem_rvalid;
    logic [DATA_W-1:0]       mem_rdata;
    logic                    cpu_rsp_valid;
    logic [DATA_W-1:0]       cpu_rsp_data;
    logic                    hit_req;
    logic [LINE_W-1:0]       hit_line;
    logic [2:0]              hit_offset;
    logic                    hit_rsp_valid;
    logic [DATA_W-1:0]       hit_rsp_data;
    logic                    fill_done;
    logic [DATA_W*WORDS-1:0] fill_line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cwf_line_fill #(.DATA_W(DATA_W), .WORDS(WORDS), .LINE_W(LINE_W)) dut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_line(miss_line),
        .miss_offset(miss_offset), .miss_wrap(miss_wrap),
        .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_req_first(mem_req_first),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
        .hit_req(hit_req), .hit_line(hit_line), .hit_offset(hit_offset),
        .hit_rsp_valid(hit_rsp_valid), .hit_rsp_data(hit_rsp_data),
        .fill_done(fill_done), .fill_line(fill_line)
    );

    function automatic logic [DATA_W-1:0] wdat(input logic [LINE_W-1:0] ln,
                                               input logic [2:0] w);
        return {ln[15:0], 8'hA5, 5'b0, w};
    endfunction

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_miss(input logic wrap, input logic [LINE_W-1:0] ln,
                            input logic [2:0] off, input logic [7:0] gaps);
        int rsp_seen = 0;
        logic [2:0] w;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R1 ready before miss", 64'(miss_ready), 64'd1);
        miss_valid = 1'b1; miss_line = ln; miss_offset = off; miss_wrap = wrap;
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        chk(mem_req_valid == 1'b1, "R1 request pulse", 64'(mem_req_valid), 64'd1);
        chk(mem_req_line == ln, "R1 request line", 64'(mem_req_line), 64'(ln));
        chk(mem_req_first == (wrap ? off : 3'd0), "R1 first word",
            64'(mem_req_first), 64'(wrap ? off : 3'd0));
        chk(cpu_rsp_valid == 1'b0, "R4 no response before beats",
            64'(cpu_rsp_valid), 64'd0);
        @(posedge clk);
        for (int b = 0; b < WORDS; b++) begin
            w = wrap ? 3'(off + 3'(b)) : 3'(b);
            if (gaps[b]) begin
                @(negedge clk);
                mem_rvalid = 1'b0;
                if (b == 2) begin
                    miss_valid = 1'b1; miss_line = ln ^ 27'h55; miss_offset = 3'd1;
                end
                #1;
                chk(cpu_rsp_valid == 1'b0, "R4 quiet in gap", 64'(cpu_rsp_valid), 64'd0);
                chk(miss_ready == 1'b0, "R7 busy during fill", 64'(miss_ready), 64'd0);
                @(posedge clk);
                miss_valid = 1'b0;
            end
            if (b == 4) begin
                @(negedge clk);
                mem_rvalid = 1'b0;
                hit_req = 1'b1; hit_line = ln;
                hit_offset = wrap ? 3'(off + 3'd3) : 3'd3;
                #0.5;
                chk(hit_rsp_valid == 1'b1, "R8 hit on arrived word",
                    64'(hit_rsp_valid), 64'd1);
                chk(hit_rsp_data == wdat(ln, hit_offset), "R8 hit data",
                    64'(hit_rsp_data), 64'(wdat(ln, hit_offset)));
                hit_offset = w;
                #0.5;
                chk(hit_rsp_valid == 1'b0, "R8 no hit on pending word",
                    64'(hit_rsp_valid), 64'd0);
                hit_req = 1'b0;
                @(posedge clk);
            end
            @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = wdat(ln, w);
            #1;
            chk(mem_req_valid == 1'b0, "R7 no second request",
                64'(mem_req_valid), 64'd0);
            chk(cpu_rsp_valid == (w == off), wrap ? "R2 R4 response beat" : "R3 R4 response beat",
                64'(cpu_rsp_valid), 64'(w == off));
            if (cpu_rsp_valid) begin
                rsp_seen++;
                chk(cpu_rsp_data == wdat(ln, off), "R4 response data",
                    64'(cpu_rsp_data), 64'(wdat(ln, off)));
            end
            @(posedge clk);
        end
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        chk(fill_done == 1'b1, "R6 done after last beat", 64'(fill_done), 64'd1);
        chk(miss_ready == 1'b0, "R7 busy in done cycle", 64'(miss_ready), 64'd0);
        chk(rsp_seen == 1, "R5 one response per miss", 64'(rsp_seen), 64'd1);
        for (int k = 0; k < WORDS; k++) begin
            chk(fill_line[k*DATA_W +: DATA_W] == wdat(ln, 3'(k)),
                wrap ? "R2 R6 line word" : "R3 R6 line word",
                64'(fill_line[k*DATA_W +: DATA_W]), 64'(wdat(ln, 3'(k))));
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(fill_done == 1'b0, "R6 done is one cycle", 64'(fill_done), 64'd0);
        chk(miss_ready == 1'b1, "R7 ready after done", 64'(miss_ready), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [LINE_W-1:0] last_ln;
        rst = 1'b1; miss_valid = 1'b0; miss_line = '0; miss_offset = '0;
        miss_wrap = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        hit_req = 1'b0; hit_line = '0; hit_offset = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(miss_ready == 1'b1, "R10 reset ready", 64'(miss_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R10 reset request", 64'(mem_req_valid), 64'd0);
        chk(cpu_rsp_valid == 1'b0, "R10 reset response", 64'(cpu_rsp_valid), 64'd0);
        chk(fill_done == 1'b0, "R10 reset done", 64'(fill_done), 64'd0);
        chk(fill_line == '0, "R10 reset line", 64'(fill_line[63:0]), 64'd0);
        hit_req = 1'b1;
        #1;
        chk(hit_rsp_valid == 1'b0, "R10 R8 no hit after reset", 64'(hit_rsp_valid), 64'd0);
        hit_req = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            run_miss(VECS[v].wrap, {11'b0, VECS[v].line}, VECS[v].off, VECS[v].gaps);
        end
        last_ln = {11'b0, VECS[NVEC-1].line};

        // R9: stray beats while idle are dropped
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
        #1;
        chk(cpu_rsp_valid == 1'b0, "R9 no response to idle beat", 64'(cpu_rsp_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        #1;
        chk(fill_line[0 +: DATA_W] == wdat(last_ln, 3'd0), "R9 buffer unchanged",
            64'(fill_line[0 +: DATA_W]), 64'(wdat(last_ln, 3'd0)));
        chk(mem_req_valid == 1'b0, "R9 no request from idle beat", 64'(mem_req_valid), 64'd0);
        hit_req = 1'b1; hit_line = last_ln; hit_offset = 3'd0;
        #0.5;
        chk(hit_rsp_valid == 1'b1 && hit_rsp_data == wdat(last_ln, 3'd0),
            "R8 R9 hit after fill", 64'(hit_rsp_data), 64'(wdat(last_ln, 3'd0)));
        hit_line = last_ln ^ 27'h1;
        #0.5;
        chk(hit_rsp_valid == 1'b0, "R8 other line misses", 64'(hit_rsp_valid), 64'd0);
        hit_req = 1'b0;

        // back-to-back miss right after ready returns
        run_miss(1'b1, 27'h7FF_FFFF, 3'd3, 8'b0000_0001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule